// File: doc/BRIEF.md
# Cascadable Interrupt Controller

This block arbitrates eight interrupt request lines for a processor. It has a byte-wide register port with four addresses. Before it does anything, software writes a fixed four-word start-up sequence. The sequence sets the vector base and tells the block which cascade role it plays. Once the sequence is complete, the block accepts mask writes and specific end-of-interrupt (EOI) commands. It keeps three eight-bit registers: pending requests, in-service levels and the mask. It raises `int_o` when an unmasked request outranks everything in service. When the processor acknowledges, the block answers with an 8-bit vector.

A trigger register selects edge or level detection for each input. Two instances form a sixteen-input pair. The slave's `int_o` drives one master input. During each acknowledge the master announces the winning level on `cas_o`, and the slave drives the vector only when that value equals its own identity. A request on the slave is retired with a specific EOI on the slave and then a specific EOI on the master for the line the slave is wired to.

Top module: `pic_core`

## Requirements
- R1: After reset, all registers read 0, `int_o` and `vec_en_o` are low, and the block is uninitialised. While uninitialised, `int_o` stays low whatever the inputs do.
- R2: A write to address 0 with bit 4 set begins initialisation. The next three writes to address 1 are taken as the vector base, then the cascade word, then the mode word. They are not taken as mask writes. Only after the third of these do mask writes, EOIs and `int_o` take effect.
- R3: A write that begins initialisation, issued at any time, clears the mask, the pending requests and the in-service levels. It also returns the block to the uninitialised state.
- R4: Once initialised, a write to address 1 loads the mask, which reads back at address 1. A 1 bit blocks that input from `int_o` but does not stop the input's request from being recorded.
- R5: An input whose trigger bit is 0 (edge mode) records a request on its rising edge. The request is held after the input falls, until that level is acknowledged.
- R6: An input whose trigger bit is 1 (level mode) has a request that follows the input, one cycle later.
- R7: Priority is fixed, and the lowest input index wins. `int_o` is high only when the winning unmasked request has a lower index than every in-service level.
- R8: `inta_i` is a one-cycle acknowledge. In the following cycle `vec_en_o` is high and `vec_o` = {base[7:3], level}. The acknowledge also sets that in-service bit and clears an edge request. With nothing eligible, the acknowledge returns level 7 and changes no in-service bit.
- R9: A write to address 0 with bits 7:5 = 011 and bit 4 = 0 is a specific EOI. It clears only the in-service bit numbered by bits 2:0.
- R10: On a master (`slave_i` = 0), `cas_o` carries the winning level during an acknowledge. If that level's bit is set in the cascade word, the master records it in service but leaves `vec_en_o` low.
- R11: On a slave (`slave_i` = 1), the cascade word bits 2:0 are its identity. The slave answers an acknowledge only when `cas_i` equals that identity, and its `cas_o` is 0.
- R12: The read map is: address 0 pending requests, address 1 mask, address 2 trigger, address 3 in-service. The trigger register is written at address 2 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| slave_i | input | 1 | Role: 1 = slave |
| ir_i | input | 8 | Interrupt request lines |
| int_o | output | 1 | Interrupt to the processor |
| inta_i | input | 1 | Acknowledge pulse |
| cas_i | input | 3 | Level announced by the master |
| cas_o | output | 3 | Winning level announced to slaves |
| vec_o | output | 8 | Vector, valid with `vec_en_o` |
| vec_en_o | output | 1 | This instance drives the vector |

## Verification
Directed single-edge pulses separate latched edge requests from level requests that follow the input. Two simultaneous edges on inputs 4 and 6 show whether priority ordering is decided by index. A nested sequence (acknowledge 1, then raise 0, then EOI 1) shows whether EOI clears only the named bit. A seeded random phase varies the mask and the level inputs and compares `int_o`, the vectors and the in-service readback against a model; this finds nesting errors that directed cases miss. A master/slave pair, run once with the slave alone and once while a master input competes, shows whether the slave answers only when its identity is called.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  typedef enum logic [2:0] {ST_OFF, ST_W2, ST_W3, ST_W4, ST_RUN} init_st_e;
  localparam logic [1:0] ADR_CMD = 2'd0;
  localparam logic [1:0] ADR_DAT = 2'd1;
  localparam logic [1:0] ADR_TRG = 2'd2;
  localparam logic [1:0] ADR_ISR = 2'd3;
  localparam int         INIT_BIT = 4;
  localparam logic [2:0] EOI_CODE = 3'b011;
endpackage

// File: rtl/pic_prio.sv
`timescale 1ns/1ps
module pic_prio #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    // descending scan: lowest set index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/pic_req.sv
`timescale 1ns/1ps
module pic_req #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [N-1:0] ir_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] irr_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q, irr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        irr_q  <= 1'b0;
      end else begin
        prev_q <= ir_i[g];
        if (clr_all_i)        irr_q <= 1'b0;
        else if (level_i[g])  irr_q <= ir_i[g];
        else                  irr_q <= (irr_q & ~ack_clr_i[g]) | (ir_i[g] & ~prev_q);
      end
    end
    assign irr_o[g] = irr_q;
  end
endmodule

// File: rtl/pic_core.sv
`timescale 1ns/1ps
module pic_core #(
  parameter int N_IN  = 8,
  parameter int VEC_W = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [VEC_W-1:0] wdata_i,
  output logic [VEC_W-1:0] rdata_o,
  input  logic             slave_i,
  input  logic [N_IN-1:0]  ir_i,
  output logic             int_o,
  input  logic             inta_i,
  input  logic [LVL_W-1:0] cas_i,
  output logic [LVL_W-1:0] cas_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_en_o
);
  import pic_pkg::*;

  localparam logic [LVL_W-1:0] LVL_SPUR = LVL_W'(N_IN - 1);

  init_st_e          st_q;
  logic [VEC_W-1:0]  base_q, vec_q;
  logic [N_IN-1:0]   casc_q, imr_q, trg_q, isr_q;
  logic              vec_en_q;

  logic              ready_w, wr_init, wr_eoi, wr_dat, wr_trg;
  logic [N_IN-1:0]   irr_w, pend_w, ack_clr, eoi_mask;
  logic              p_any, s_any, outrank, take, hit, cascaded;
  logic [LVL_W-1:0]  p_idx, s_idx, lvl_w;

  assign ready_w = (st_q == ST_RUN);
  assign wr_init = we_i && addr_i == ADR_CMD && wdata_i[INIT_BIT];
  assign wr_eoi  = we_i && addr_i == ADR_CMD && !wdata_i[INIT_BIT]
                   && wdata_i[7:5] == EOI_CODE && ready_w;
  assign wr_dat  = we_i && addr_i == ADR_DAT;
  assign wr_trg  = we_i && addr_i == ADR_TRG;

  pic_req #(.N(N_IN)) u_req (
    .clk_i, .rst_ni,
    .clr_all_i(wr_init),
    .ir_i,
    .level_i(trg_q),
    .ack_clr_i(ack_clr),
    .irr_o(irr_w)
  );

  assign pend_w = irr_w & ~imr_q;

  pic_prio #(.N(N_IN), .W(LVL_W)) u_prio_req (.vec_i(pend_w), .any_o(p_any), .idx_o(p_idx));
  pic_prio #(.N(N_IN), .W(LVL_W)) u_prio_isr (.vec_i(isr_q),  .any_o(s_any), .idx_o(s_idx));

  assign outrank  = p_any && (!s_any || p_idx < s_idx);
  assign int_o    = ready_w && outrank;
  assign take     = ready_w && inta_i && (!slave_i || cas_i == casc_q[LVL_W-1:0]);
  assign hit      = take && outrank;
  assign cascaded = !slave_i && casc_q[p_idx];
  assign ack_clr  = hit ? (N_IN'(1) << p_idx) : '0;
  assign eoi_mask = wr_eoi ? (N_IN'(1) << wdata_i[LVL_W-1:0]) : '0;
  assign lvl_w    = hit ? p_idx : LVL_SPUR;
  assign cas_o    = (!slave_i && ready_w && p_any) ? p_idx : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      base_q <= '0;
      casc_q <= '0;
    end else if (wr_init) begin
      st_q <= ST_W2;
    end else if (wr_dat) begin
      case (st_q)
        ST_W2: begin base_q <= wdata_i;           st_q <= ST_W3; end
        ST_W3: begin casc_q <= wdata_i[N_IN-1:0]; st_q <= ST_W4; end
        ST_W4: st_q <= ST_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q <= '0;
      isr_q <= '0;
      trg_q <= '0;
    end else begin
      if (wr_trg) trg_q <= wdata_i[N_IN-1:0];
      if (wr_init) begin
        imr_q <= '0;
        isr_q <= '0;
      end else begin
        if (ready_w && wr_dat) imr_q <= wdata_i[N_IN-1:0];
        isr_q <= (isr_q & ~eoi_mask) | ack_clr;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q    <= '0;
      vec_en_q <= 1'b0;
    end else begin
      vec_en_q <= take && !(hit && cascaded);
      if (take) vec_q <= {base_q[VEC_W-1:LVL_W], lvl_w};
    end
  end

  assign vec_o    = vec_q;
  assign vec_en_o = vec_en_q;

  always_comb begin
    case (addr_i)
      ADR_CMD: rdata_o = VEC_W'(irr_w);
      ADR_DAT: rdata_o = VEC_W'(imr_q);
      ADR_TRG: rdata_o = VEC_W'(trg_q);
      default: rdata_o = VEC_W'(isr_q);
    endcase
  end
endmodule

// File: rtl/pic_core_chk.sv
`timescale 1ns/1ps
module pic_core_chk #(
  parameter int N_IN  = 8,
  parameter int VEC_W = 8,
  parameter int LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [VEC_W-1:0] wdata_i,
  input logic             inta_i,
  input logic             int_o,
  input logic             vec_en_o,
  input logic             ready,
  input logic [N_IN-1:0]  irr,
  input logic [N_IN-1:0]  imr,
  input logic [N_IN-1:0]  isr
);
  // R1
  unready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> !int_o);

  // R7
  int_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (irr & ~imr) != '0);

  // R8
  vec_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_en_o |-> $past(inta_i));

  // R3
  init_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0 && wdata_i[4]) |=> (isr == '0 && imr == '0 && !ready));

  // R9
  eoi_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && we_i && addr_i == 2'd0 && !wdata_i[4] && wdata_i[7:5] == 3'b011 && !inta_i)
    |=> !isr[$past(wdata_i[LVL_W-1:0])]);

  // R4
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && we_i && addr_i == 2'd1) |=> imr == $past(wdata_i[N_IN-1:0]));
endmodule

bind pic_core pic_core_chk #(.N_IN(N_IN), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .inta_i, .int_o, .vec_en_o,
  .ready(ready_w), .irr(irr_w), .imr(imr_q), .isr(isr_q)
);

// File: tb/pic_core_test.sv
`timescale 1ns/1ps
module pic_core_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_we = 0, s_we = 0, inta = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, m_ir = '0, s_ir = '0;
  logic [7:0] m_rd, s_rd, m_vec, s_vec;
  logic m_int, s_int, m_ven, s_ven;
  logic [2:0] m_cas, s_cas;
  logic [7:0] m_ir_w;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;
  assign m_ir_w = {m_ir[7:3], s_int, m_ir[1:0]};

  pic_core uut (.clk_i(clk), .rst_ni(rst_n), .we_i(m_we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(m_rd), .slave_i(1'b0), .ir_i(m_ir_w), .int_o(m_int), .inta_i(inta),
    .cas_i(3'd0), .cas_o(m_cas), .vec_o(m_vec), .vec_en_o(m_ven));
  pic_core slv (.clk_i(clk), .rst_ni(rst_n), .we_i(s_we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(s_rd), .slave_i(1'b1), .ir_i(s_ir), .int_o(s_int), .inta_i(inta),
    .cas_i(m_cas), .cas_o(s_cas), .vec_o(s_vec), .vec_en_o(s_ven));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wr(input bit s, input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d;
    if (s) s_we = 1; else m_we = 1;
    tick();
    m_we = 0; s_we = 0;
  endtask
  task automatic rd(input bit s, input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = s ? s_rd : m_rd;
  endtask
  task automatic ack(); inta = 1; tick(); inta = 0; endtask
  function automatic int low(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction
  task automatic done();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL watchdog expired");
    done();
  end

  initial begin
    logic [7:0] d, isr_m, mask, ir, pend;
    int w, t, seed;
    seed = $urandom(32'd1234);
    m_ir = 8'h01;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 / R12 reset state
    for (int a = 0; a < 4; a++) begin
      rd(0, 2'(a), d);
      // rdata at address 0 reflects the level on input 0? edge mode: rise was during reset
      if (a != 0) chk("R1 reset regs", d, 0);
    end
    tick();
    chk("R1 int low before init", m_int, 0);
    chk("R1 vec_en low", m_ven, 0);
    m_ir = 0; tick();
    // R2 init master
    wr(0, 0, 8'h11); wr(0, 1, 8'h20);
    rd(0, 1, d); chk("R2 base word not mask", d, 0);
    wr(0, 1, 8'h04);
    chk("R2 not ready before mode word", m_int, 0);
    wr(0, 1, 8'h01);
    wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    chk("R11 slave cas_o zero", s_cas, 0);
    // R4 mask readback
    wr(0, 1, 8'hFF); rd(0, 1, d); chk("R4 mask readback", d, 8'hFF);
    wr(0, 1, 8'h00);
    // R5 edge
    m_ir[0] = 1; tick(); m_ir[0] = 0; tick();
    rd(0, 0, d); chk("R5 edge held", d, 8'h01);
    chk("R5 int raised", m_int, 1);
    ack();
    chk("R8 vec_en", m_ven, 1); chk("R8 vector 0", m_vec, 8'h20);
    rd(0, 3, d); chk("R8 isr set", d, 8'h01);
    rd(0, 0, d); chk("R8 edge request cleared", d, 0);
    m_ir[1] = 1; tick(); m_ir[1] = 0;
    chk("R7 blocked by in-service", m_int, 0);
    wr(0, 0, 8'h60);
    rd(0, 3, d); chk("R9 eoi 0", d, 0);
    chk("R7 int after eoi", m_int, 1);
    ack(); chk("R8 vector 1", m_vec, 8'h21);
    m_ir[0] = 1; tick(); m_ir[0] = 0;
    chk("R7 higher level nests", m_int, 1);
    ack(); chk("R8 nested vector", m_vec, 8'h20);
    rd(0, 3, d); chk("R8 two in service", d, 8'h03);
    wr(0, 0, 8'h61);
    rd(0, 3, d); chk("R9 only named bit", d, 8'h01);
    wr(0, 0, 8'h60);
    // R6 level
    wr(0, 2, 8'h08); rd(0, 2, d); chk("R12 trigger readback", d, 8'h08);
    m_ir[3] = 1; tick();
    rd(0, 0, d); chk("R6 level follows high", d, 8'h08);
    chk("R6 int", m_int, 1);
    m_ir[3] = 0; tick();
    rd(0, 0, d); chk("R6 level follows low", d, 0);
    chk("R6 int drops", m_int, 0);
    // R4 masking
    m_ir[3] = 1; wr(0, 1, 8'h08); tick();
    chk("R4 masked no int", m_int, 0);
    rd(0, 0, d); chk("R4 request still recorded", d, 8'h08);
    wr(0, 1, 8'h00); chk("R4 unmasked int", m_int, 1);
    m_ir[3] = 0; tick();
    // R7 priority
    m_ir[4] = 1; m_ir[6] = 1; tick(); m_ir[4] = 0; m_ir[6] = 0;
    ack(); chk("R7 lower index wins", m_vec, 8'h24);
    wr(0, 0, 8'h64);
    ack(); chk("R7 next level", m_vec, 8'h26);
    wr(0, 0, 8'h66);
    // R8 spurious
    ack(); chk("R8 spurious vec_en", m_ven, 1); chk("R8 spurious vector", m_vec, 8'h27);
    rd(0, 3, d); chk("R8 spurious no isr", d, 0);
    // R10/R11 cascade
    s_ir[5] = 1; tick(); s_ir[5] = 0; tick();
    chk("R10 master int via slave", m_int, 1);
    inta = 1; #1; chk("R10 cas_o level", m_cas, 2); tick(); inta = 0;
    chk("R10 master silent", m_ven, 0);
    chk("R11 slave drives", s_ven, 1); chk("R11 slave vector", s_vec, 8'h2D);
    rd(0, 3, d); chk("R10 master isr", d, 8'h04);
    rd(1, 3, d); chk("R11 slave isr", d, 8'h20);
    wr(1, 0, 8'h65); wr(0, 0, 8'h62);
    rd(0, 3, d); chk("R9 master cleared", d, 0);
    s_ir[5] = 1; m_ir[0] = 1; tick(); s_ir[5] = 0; m_ir[0] = 0; tick();
    inta = 1; #1; chk("R10 cas_o other level", m_cas, 0); tick(); inta = 0;
    chk("R11 master vector", m_vec, 8'h20); chk("R11 master drives", m_ven, 1);
    chk("R11 slave not selected", s_ven, 0);
    rd(1, 3, d); chk("R11 slave isr untouched", d, 0);
    wr(0, 0, 8'h60);
    chk("R10 pending slave", m_int, 1);
    ack(); chk("R11 slave later", s_vec, 8'h2D); chk("R11 slave en", s_ven, 1);
    chk("R10 master silent again", m_ven, 0);
    wr(1, 0, 8'h65); wr(0, 0, 8'h62);
    // random phase, level inputs on master
    wr(0, 2, 8'hFB);
    isr_m = 0;
    for (int it = 0; it < 60; it++) begin
      mask = 8'($urandom);
      wr(0, 1, mask);
      ir = 8'($urandom) & 8'hFB;
      m_ir = ir; tick(); tick();
      pend = ir & ~mask;
      w = low(pend); t = low(isr_m);
      chk("R7 random int", m_int, (w < 8 && w < t) ? 1 : 0);
      if (w < 8 && w < t) begin
        ack();
        chk("R8 random vector", m_vec, 8'h20 | 8'(w));
        isr_m[w] = 1'b1;
      end
      if (($urandom % 2) == 1 && isr_m != 0) begin
        t = low(isr_m);
        wr(0, 0, 8'h60 | 8'(t));
        isr_m[t] = 1'b0;
      end
      rd(0, 3, d); chk("R9 random isr", d, isr_m);
    end
    m_ir = 0;
    for (int l = 0; l < 8; l++) wr(0, 0, 8'h60 | 8'(l));
    // R3 restart
    wr(0, 1, 8'h00);
    m_ir[0] = 1; tick(); tick();
    ack(); wr(0, 1, 8'h55);
    wr(0, 0, 8'h11);
    rd(0, 1, d); chk("R3 mask cleared", d, 0);
    rd(0, 3, d); chk("R3 isr cleared", d, 0);
    rd(0, 0, d); chk("R3 request cleared", d, 0);
    chk("R3 uninitialised", m_int, 0);
    wr(0, 1, 8'h40); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
    chk("R2 int after reinit", m_int, 1);
    ack(); chk("R2 new base", m_vec, 8'h40);
    m_ir = 0;
    done();
  end
endmodule